// File: doc/BRIEF.md
# Burst Address Counter with Recall

This block generates the address a memory port uses in each clock cycle. Each cycle it takes one of four actions. It can take an address from outside, step the address it holds up by one for a burst, keep the address it holds, or jump back to a saved recall address. The command inputs are active low.

The recall address is saved every time an external address is loaded. A recall command has the highest priority, above load and step. A status output stays low until the first load, which shows that the saved address is valid. Chip-enable and byte-enable have no effect on the counter, so they are not inputs.

The address is computed combinationally from the command in the same cycle. In flow-through use, the data therefore belongs to that same address. On the rising edge the presented address becomes the held address for the next cycle. Stepping past the all-ones address wraps to zero.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, the held address becomes 0 and `recall_ok` becomes 0. In the first cycle after reset with no command active, `mem_addr` is 0 and `recall_ok` is 0.
- R2: When `load_n`=0 and `recall_n`=1, `mem_addr` equals `addr_in` in that same cycle, whatever `step_n` is.
- R3: When `load_n`=1, `step_n`=0 and `recall_n`=1, `mem_addr` is the previous cycle's `mem_addr` plus one.
- R4: When `load_n`, `step_n` and `recall_n` are all 1, `mem_addr` repeats the previous cycle's value and `addr_in` has no effect.
- R5: When `recall_n`=0 and `recall_ok`=1, `mem_addr` equals the last address loaded by R2, whatever `load_n` and `step_n` are. A load requested in the same cycle neither takes effect nor updates the saved address.
- R6: Every load by R2 stores `addr_in` as the recall address and sets `recall_ok` to 1 from the next cycle on.
- R7: When `recall_n`=0 while `recall_ok`=0, `mem_addr` repeats the previous cycle's value.
- R8: Stepping from the all-ones address gives address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low external address load |
| step_n | input | 1 | Active-low increment request |
| recall_n | input | 1 | Active-low jump to the saved recall address |
| addr_in | input | AW | External address |
| mem_addr | output | AW | Address used for this cycle's access |
| recall_ok | output | 1 | High once a recall address has been saved |

## Verification
Assertions check the following every cycle: that a load passes `addr_in` straight through, that a step adds one to the previous address and a hold keeps it, that a recall before any load keeps the address, and that `recall_ok` only rises after a load. Some behaviours can only be shown by the bench's scenarios. These are that a recall returns exactly the address of the most recent load, that a load given together with a recall leaves the saved address unchanged, and that stepping wraps from all-ones to zero.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD   = 2'd0,
    CMD_STEP   = 2'd1,
    CMD_LOAD   = 2'd2,
    CMD_RECALL = 2'd3
  } bag_cmd_e;
endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import bag_pkg::*;
(
  input  logic     load_n,
  input  logic     step_n,
  input  logic     recall_n,
  output bag_cmd_e cmd
);
  // Recall outranks load, and load outranks step.
  always_comb begin
    if (!recall_n)    cmd = CMD_RECALL;
    else if (!load_n) cmd = CMD_LOAD;
    else if (!step_n) cmd = CMD_STEP;
    else              cmd = CMD_HOLD;
  end
endmodule

// File: rtl/bag_recall_reg.sv
module bag_recall_reg
  import bag_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  bag_cmd_e      cmd,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] saved,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      saved <= '0;
      valid <= 1'b0;
    end else if (cmd == CMD_LOAD) begin
      saved <= addr_in;
      valid <= 1'b1;
    end
  end

  // R6: a load is always followed by a valid saved copy of the address
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_LOAD) |=> (valid && saved == $past(addr_in)));

  // R5: the saved address changes only on a load
  a_r5_saved_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd != CMD_LOAD) |=> (saved == $past(saved)));
endmodule

// File: rtl/bag_next.sv
module bag_next
  import bag_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  bag_cmd_e      cmd,
  input  logic [AW-1:0] addr_in,
  input  logic [AW-1:0] saved,
  input  logic          valid,
  output logic [AW-1:0] addr_now
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] held_q;

  always_comb begin
    unique case (cmd)
      CMD_LOAD:   addr_now = addr_in;
      CMD_STEP:   addr_now = held_q + ONE;   // wraps naturally at AW bits
      CMD_RECALL: addr_now = valid ? saved : held_q;
      default:    addr_now = held_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) held_q <= '0;
    else     held_q <= addr_now;
  end

  // R3/R4: the held address is exactly what the previous cycle presented
  a_r3_continuity: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (held_q == $past(addr_now)));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          recall_n,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] mem_addr,
  output logic          recall_ok
);
  bag_cmd_e      cmd;
  logic [AW-1:0] saved;
  logic          valid;

  bag_decode u_dec (
    .load_n  (load_n),
    .step_n  (step_n),
    .recall_n(recall_n),
    .cmd     (cmd)
  );

  bag_recall_reg #(.AW(AW)) u_rcl (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd),
    .addr_in(addr_in),
    .saved  (saved),
    .valid  (valid)
  );

  bag_next #(.AW(AW)) u_nxt (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .addr_in (addr_in),
    .saved   (saved),
    .valid   (valid),
    .addr_now(mem_addr)
  );

  assign recall_ok = valid;

  // Marks cycles whose previous cycle was out of reset, so $past is meaningful.
  logic run_q;
  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= 1'b1;
  end

  a_r2_load_pass: assert property (@(posedge clk) disable iff (rst)
    (!load_n && recall_n) |-> (mem_addr == addr_in));

  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (run_q && load_n && !step_n && recall_n) |-> (mem_addr == $past(mem_addr) + AW'(1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (run_q && load_n && step_n && recall_n) |-> (mem_addr == $past(mem_addr)));

  a_r7_early_recall: assert property (@(posedge clk) disable iff (rst)
    (run_q && !recall_n && !recall_ok) |-> (mem_addr == $past(mem_addr)));

  a_r1_flag_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(recall_ok) |-> $past(!load_n && recall_n));
endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] addr;
    logic          ok;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_n = 1'b1, step_n = 1'b1, recall_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] mem_addr;
  logic          recall_ok;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  exp_t q[$];

  logic [AW-1:0] m_cur = '0, m_saved = '0;
  logic          m_ok = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .load_n(load_n), .step_n(step_n),
    .recall_n(recall_n), .addr_in(addr_in),
    .mem_addr(mem_addr), .recall_ok(recall_ok)
  );

  // Driver: applies one command per cycle and queues the expected outputs.
  task automatic apply(input logic ld, input logic st, input logic rc,
                       input logic [AW-1:0] a, input string tag);
    exp_t e;
    logic [AW-1:0] nxt;
    @(negedge clk);
    load_n = ld; step_n = st; recall_n = rc; addr_in = a;
    if (!rc)      nxt = m_ok ? m_saved : m_cur;
    else if (!ld) nxt = a;
    else if (!st) nxt = m_cur + AW'(1);
    else          nxt = m_cur;
    e.addr = nxt; e.ok = m_ok; e.tag = tag;
    q.push_back(e);
    m_cur = nxt;
    if (rc && !ld) begin
      m_saved = a;
      m_ok = 1'b1;
    end
  endtask

  // Monitor: samples just after the driver has settled the inputs.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (mem_addr !== e.addr || recall_ok !== e.ok) begin
          errors++;
          $display("FAIL %s: addr=%h ok=%b expected addr=%h ok=%b",
                   e.tag, mem_addr, recall_ok, e.addr, e.ok);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    apply(1, 1, 1, 20'h0ABCD, "R1 reset idle");
    apply(1, 1, 0, 20'h00123, "R7 recall before load");
    apply(1, 0, 1, 20'h00777, "R3 step from reset");
    apply(1, 0, 0, 20'h00777, "R7 recall+step before load");
    apply(0, 0, 1, 20'h00100, "R2 load with step low");
    apply(1, 0, 1, 20'h0FFFF, "R6 flag set / R3 step");
    apply(1, 0, 1, 20'h00000, "R3 step");
    apply(1, 0, 1, 20'h00000, "R3 step");
    apply(1, 1, 1, 20'h55555, "R4 hold ignores addr_in");
    apply(1, 1, 1, 20'hAAAAA, "R4 hold ignores addr_in");
    apply(0, 1, 0, 20'h00555, "R5 recall beats load");
    apply(1, 0, 1, 20'h00000, "R3 step after recall");
    apply(1, 1, 0, 20'h00000, "R5 saved kept after recall+load");
    apply(0, 1, 1, 20'hFFFFE, "R2 load high");
    apply(1, 0, 1, 20'h00000, "R3 step to all-ones");
    apply(1, 0, 1, 20'h00000, "R8 wrap to zero");
    apply(1, 0, 1, 20'h00000, "R8 step after wrap");
    apply(0, 0, 1, 20'h0002A, "R2 load again");
    apply(1, 0, 0, 20'h00000, "R6 recall returns latest load");
    apply(0, 0, 0, 20'h00999, "R5 recall beats load and step");
    apply(0, 1, 1, 20'hFFFFF, "R2 load all-ones");
    apply(1, 1, 0, 20'h00000, "R6 recall all-ones");
    apply(1, 0, 1, 20'h00000, "R8 wrap after recall");
    @(negedge clk);
    load_n = 1'b1; step_n = 1'b1; recall_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule